// File: doc/BRIEF.md
# Serial GPIO chain controller

The block drives an external daisy chain of shift registers that carries up to 32 ports, each 1 to 4 bits wide. It makes a divided serial clock, shifts out one output bit per chain position, and samples the serial input returning from the chain. After the last position it raises a load strobe for one serial clock period so the external registers transfer their contents. Ports whose enable bit is clear take no chain position at all.

Configuration comes in on plain control pins: the port width (bits per port minus one), a 12-bit clock divider, an auto-repeat flag, a 32-bit port enable mask and a one-cycle frame start pulse. Each port owns a 12-bit output configuration word, held inside the block and written through a simple write strobe; it holds a 3-bit source field per bit, and the lowest bit of each field is the value shifted out. Captured inputs are presented as four 32-bit words, one per bit index, where each word collects that bit index from every port. There is no data stream at the block's edge, so no valid/ready handshake is used; every pin is a plain control or status pin.

Top module: `sgpio_chain`

## Requirements
- R1: After reset every output configuration word is zero, `in_words` is zero and `sio_clk`, `sio_ld` and `sio_dout` are low; a frame run before any write shifts out only zeros.
- R2: A chain position lasts r system clock cycles; `sio_clk` is low for the first floor(r/2) of them and high for the rest. Outside chain positions `sio_clk` is low.
- R3: The ratio r equals `cfg_div`, except that `cfg_div` values 0 and 1 give r = 2.
- R4: Within a frame, enabled ports are visited in ascending port number and, within a port, bits 0 up to `cfg_width` in ascending order (`cfg_width` = bits per port minus one).
- R5: A port whose bit in `cfg_port_ena` is 0 takes no chain position and its bits in `in_words` read 0.
- R6: During the position of port p, bit b, `sio_dout` equals bit 3*b of port p's output configuration word (the low bit of the 3-bit field at bits 3*b+2..3*b); all other word bits have no effect. Outside positions `sio_dout` is low.
- R7: Right after the last position `sio_ld` is high for exactly r cycles, with `sio_clk` low, and is low otherwise.
- R8: `sio_din` is sampled on the last system cycle of each position; bit p of word b, found at `in_words[32*b+p]`, is the sample for port p bit b. Bits above `cfg_width` read 0.
- R9: `in_words` changes only at the end of the load period, all bits together.
- R10: With `cfg_repeat` at 1 a new frame starts right after each load period; with it at 0 a frame starts only on a `frame_start` pulse while idle, and a pulse during a frame is ignored.
- R11: While `cfg_port_ena` is zero no frame starts: `sio_clk` and `sio_ld` stay low.
- R12: Width, divider and enable mask are captured when a frame starts; changing them during the frame does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bits per port minus one |
| cfg_div | input | 12 | Serial clock divide ratio |
| cfg_repeat | input | 1 | Run frames back to back |
| cfg_port_ena | input | 32 | Ports taking part in the chain |
| frame_start | input | 1 | Start one frame when idle |
| ocfg_we | input | 1 | Write strobe for an output configuration word |
| ocfg_port | input | 5 | Port whose word is written |
| ocfg_data | input | 12 | Output configuration word, 3 bits per port bit |
| sio_clk | output | 1 | Serial clock to the chain |
| sio_dout | output | 1 | Serial data to the chain |
| sio_ld | output | 1 | Load strobe to the chain |
| sio_din | input | 1 | Serial data returning from the chain |
| in_words | output | 128 | Captured inputs, word b at bits 32*b+31..32*b |

## Verification
On every cycle the assertions check that the load strobe and serial clock never overlap, that the latched ratio never drops below 2, that only enabled ports and in-range bit indices are visited, that the serial clock rises exactly at mid-position, that captured words hold still except at the end of a load period, and that an empty mask keeps the block idle. The bench's reference model compares all outputs every cycle, but only its scenarios show the visiting order against written output words, the regrouping of sampled bits into per-bit-index words, the floor on the divider, back-to-back repetition, and that a mid-frame configuration change or start pulse leaves the running frame alone.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int unsigned SG_FLDW = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } sg_state_e;
endpackage

// File: rtl/sgpio_cfg_store.sv
module sgpio_cfg_store #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned PW     = 5,
  parameter int unsigned BW     = 2,
  parameter int unsigned CFGW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_port,
  input  logic [CFGW-1:0] wr_data,
  input  logic [PW-1:0]   rd_port,
  input  logic [BW-1:0]   rd_bit,
  output logic            rd_val
);
  import sgpio_pkg::*;

  logic [NPORTS*CFGW-1:0] words_flat;
  logic [CFGW-1:0]        sel_word;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic [CFGW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (wr_port == PW'(g)))
        word_q <= wr_data;
    end
    assign words_flat[g*CFGW +: CFGW] = word_q;
  end

  always_comb begin
    sel_word = words_flat[int'(rd_port)*CFGW +: CFGW];
    rd_val   = sel_word[int'(rd_bit)*SG_FLDW];
  end
endmodule

// File: rtl/sgpio_port_scan.sv
module sgpio_port_scan #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned PW     = 5
) (
  input  logic [NPORTS-1:0] mask,
  input  logic [PW-1:0]     cur,
  input  logic              from_start,
  output logic              found,
  output logic [PW-1:0]     next
);
  always_comb begin
    found = 1'b0;
    next  = '0;
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (mask[p] && (from_start || (PW'(p) > cur))) begin
        found = 1'b1;
        next  = PW'(p);
      end
    end
  end
endmodule

// File: rtl/sgpio_capture.sv
module sgpio_capture #(
  parameter int unsigned NPORTS  = 32,
  parameter int unsigned MAXBITS = 4,
  parameter int unsigned PW      = 5,
  parameter int unsigned BW      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      cap,
  input  logic [PW-1:0]             cap_port,
  input  logic [BW-1:0]             cap_bit,
  input  logic                      din,
  input  logic                      commit,
  output logic [MAXBITS*NPORTS-1:0] words
);
  logic [MAXBITS*NPORTS-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shadow_q <= '0;
    else if (clr)
      shadow_q <= '0;
    else if (cap)
      shadow_q[int'(cap_bit)*NPORTS + int'(cap_port)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      words <= '0;
    else if (commit)
      words <= shadow_q;
  end
endmodule

// File: rtl/sgpio_chain.sv
module sgpio_chain #(
  parameter int unsigned NPORTS  = 32,
  parameter int unsigned MAXBITS = 4,
  parameter int unsigned DIVW    = 12,
  parameter int unsigned PW      = $clog2(NPORTS),
  parameter int unsigned BW      = $clog2(MAXBITS),
  parameter int unsigned CFGW    = MAXBITS * 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BW-1:0]             cfg_width,
  input  logic [DIVW-1:0]           cfg_div,
  input  logic                      cfg_repeat,
  input  logic [NPORTS-1:0]         cfg_port_ena,
  input  logic                      frame_start,
  input  logic                      ocfg_we,
  input  logic [PW-1:0]             ocfg_port,
  input  logic [CFGW-1:0]           ocfg_data,
  output logic                      sio_clk,
  output logic                      sio_dout,
  output logic                      sio_ld,
  input  logic                      sio_din,
  output logic [MAXBITS*NPORTS-1:0] in_words
);
  import sgpio_pkg::*;

  localparam logic [DIVW-1:0] MIN_RATIO = DIVW'(2);

  sg_state_e         st_q;
  logic [PW-1:0]     port_q;
  logic [BW-1:0]     bit_q;
  logic [BW-1:0]     w_q;
  logic [DIVW-1:0]   ph_q;
  logic [DIVW-1:0]   r_q;
  logic [NPORTS-1:0] mask_q;

  logic              ena_any;
  logic              ph_end;
  logic              launch;
  logic [DIVW-1:0]   r_new;
  logic [NPORTS-1:0] scan_mask;
  logic              scan_from_start;
  logic              scan_found;
  logic [PW-1:0]     scan_next;
  logic              cfg_bit;

  assign ena_any = |cfg_port_ena;
  assign ph_end  = (ph_q == (r_q - DIVW'(1)));
  assign r_new   = (cfg_div < MIN_RATIO) ? MIN_RATIO : cfg_div;
  assign launch  = ena_any &&
                   (((st_q == ST_IDLE) && (cfg_repeat || frame_start)) ||
                    ((st_q == ST_LOAD) && ph_end && cfg_repeat));

  assign scan_mask       = (st_q == ST_SHIFT) ? mask_q : cfg_port_ena;
  assign scan_from_start = (st_q != ST_SHIFT);

  sgpio_port_scan #(.NPORTS(NPORTS), .PW(PW)) u_scan (
    .mask       (scan_mask),
    .cur        (port_q),
    .from_start (scan_from_start),
    .found      (scan_found),
    .next       (scan_next)
  );

  sgpio_cfg_store #(.NPORTS(NPORTS), .PW(PW), .BW(BW), .CFGW(CFGW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ocfg_we),
    .wr_port (ocfg_port),
    .wr_data (ocfg_data),
    .rd_port (port_q),
    .rd_bit  (bit_q),
    .rd_val  (cfg_bit)
  );

  sgpio_capture #(.NPORTS(NPORTS), .MAXBITS(MAXBITS), .PW(PW), .BW(BW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .cap      ((st_q == ST_SHIFT) && ph_end),
    .cap_port (port_q),
    .cap_bit  (bit_q),
    .din      (sio_din),
    .commit   ((st_q == ST_LOAD) && ph_end),
    .words    (in_words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      port_q <= '0;
      bit_q  <= '0;
      w_q    <= '0;
      ph_q   <= '0;
      r_q    <= MIN_RATIO;
      mask_q <= '0;
    end else begin
      if (launch) begin
        st_q   <= ST_SHIFT;
        port_q <= scan_next;
        bit_q  <= '0;
        ph_q   <= '0;
        w_q    <= cfg_width;
        r_q    <= r_new;
        mask_q <= cfg_port_ena;
      end else begin
        case (st_q)
          ST_IDLE: ph_q <= '0;
          ST_SHIFT: begin
            if (ph_end) begin
              ph_q <= '0;
              if (bit_q == w_q) begin
                bit_q <= '0;
                if (scan_found)
                  port_q <= scan_next;
                else
                  st_q <= ST_LOAD;
              end else begin
                bit_q <= bit_q + BW'(1);
              end
            end else begin
              ph_q <= ph_q + DIVW'(1);
            end
          end
          ST_LOAD: begin
            if (ph_end) begin
              ph_q <= '0;
              st_q <= ST_IDLE;
            end else begin
              ph_q <= ph_q + DIVW'(1);
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sio_clk  = (st_q == ST_SHIFT) && (ph_q >= (r_q >> 1));
  assign sio_ld   = (st_q == ST_LOAD);
  assign sio_dout = (st_q == ST_SHIFT) && cfg_bit;
endmodule

// File: rtl/sgpio_chain_chk.sv
module sgpio_chain_chk #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned PW     = 5,
  parameter int unsigned BW     = 2,
  parameter int unsigned DIVW   = 12,
  parameter int unsigned NWBITS = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input sgpio_pkg::sg_state_e  st_q,
  input logic [PW-1:0]         port_q,
  input logic [BW-1:0]         bit_q,
  input logic [BW-1:0]         w_q,
  input logic [DIVW-1:0]       ph_q,
  input logic [DIVW-1:0]       r_q,
  input logic [NPORTS-1:0]     mask_q,
  input logic [NPORTS-1:0]     cfg_port_ena,
  input logic                  sio_clk,
  input logic                  sio_ld,
  input logic [NWBITS-1:0]     in_words
);
  import sgpio_pkg::*;

  AST_LD_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    sio_ld |-> !sio_clk); // R7

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    r_q >= DIVW'(2)); // R3

  AST_PORT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> mask_q[port_q]); // R5

  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> (bit_q <= w_q)); // R4

  AST_CLK_MID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sio_clk) |-> (ph_q == (r_q >> 1))); // R2

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !((st_q == ST_LOAD) && (ph_q == (r_q - DIVW'(1)))) |=> $stable(in_words)); // R9

  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && (cfg_port_ena == '0)) |=> (st_q == ST_IDLE)); // R11
endmodule

bind sgpio_chain sgpio_chain_chk #(
  .NPORTS (NPORTS),
  .PW     (PW),
  .BW     (BW),
  .DIVW   (DIVW),
  .NWBITS (MAXBITS * NPORTS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_q         (st_q),
  .port_q       (port_q),
  .bit_q        (bit_q),
  .w_q          (w_q),
  .ph_q         (ph_q),
  .r_q          (r_q),
  .mask_q       (mask_q),
  .cfg_port_ena (cfg_port_ena),
  .sio_clk      (sio_clk),
  .sio_ld       (sio_ld),
  .in_words     (in_words)
);

// File: tb/sgpio_chain_test.sv
module sgpio_chain_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_width = '0;
  logic [11:0]  cfg_div = 12'd2;
  logic         cfg_repeat = 1'b0;
  logic [31:0]  cfg_port_ena = '0;
  logic         frame_start = 1'b0;
  logic         ocfg_we = 1'b0;
  logic [4:0]   ocfg_port = '0;
  logic [11:0]  ocfg_data = '0;
  logic         sio_clk, sio_dout, sio_ld;
  logic         sio_din = 1'b0;
  logic [127:0] in_words;

  sgpio_chain uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_div(cfg_div),
    .cfg_repeat(cfg_repeat), .cfg_port_ena(cfg_port_ena), .frame_start(frame_start),
    .ocfg_we(ocfg_we), .ocfg_port(ocfg_port), .ocfg_data(ocfg_data),
    .sio_clk(sio_clk), .sio_dout(sio_dout), .sio_ld(sio_ld),
    .sio_din(sio_din), .in_words(in_words)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [127:0] pat = '0;
  logic [11:0]  tcfg [32];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int           m_st = 0;   // 0 idle, 1 shifting, 2 load
  int           m_ph = 0;
  int           m_r = 2;
  int           q[$];
  logic [127:0] m_sh = '0;
  logic [127:0] m_in = '0;
  logic [11:0]  mcfg [32];

  task automatic m_begin();
    m_r = (cfg_div < 2) ? 2 : int'(cfg_div);
    q.delete();
    for (int p = 0; p < 32; p++)
      if (cfg_port_ena[p])
        for (int b = 0; b <= int'(cfg_width); b++) q.push_back(p*4 + b);
    m_sh = '0;
    m_ph = 0;
    m_st = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_r = 2; q.delete(); m_sh = '0; m_in = '0;
      for (int i = 0; i < 32; i++) mcfg[i] = '0;
    end else begin
      case (m_st)
        0: if (cfg_port_ena != 0 && (cfg_repeat || frame_start)) m_begin();
        1: begin
          if (m_ph == m_r - 1) begin
            int idx;
            idx = q.pop_front();
            m_sh[(idx % 4)*32 + idx/4] = sio_din;
            m_ph = 0;
            if (q.size() == 0) m_st = 2;
          end else m_ph++;
        end
        default: begin
          if (m_ph == m_r - 1) begin
            m_in = m_sh;
            if (cfg_repeat && cfg_port_ena != 0) m_begin();
            else begin m_st = 0; m_ph = 0; end
          end else m_ph++;
        end
      endcase
      if (ocfg_we) mcfg[ocfg_port] = ocfg_data;
    end
  end

  // ---------------- per-cycle compare and stats ----------------
  int   hi_cnt = 0, ld_cnt = 0, ld_rises = 0;
  logic prev_clk = 0, prev_ld = 0;
  logic seen[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_clk, e_ld, e_dout;
      e_clk  = (m_st == 1) && (m_ph >= m_r/2);
      e_ld   = (m_st == 2);
      e_dout = 1'b0;
      if (m_st == 1 && q.size() > 0) e_dout = mcfg[q[0]/4][(q[0]%4)*3];
      chk(sio_clk == e_clk, "R2 serial clock", {127'd0, sio_clk}, {127'd0, e_clk});
      chk(sio_ld == e_ld, "R7 load strobe", {127'd0, sio_ld}, {127'd0, e_ld});
      chk(sio_dout == e_dout, "R6 serial out", {127'd0, sio_dout}, {127'd0, e_dout});
      chk(in_words == m_in, "R9 captured words", in_words, m_in);
    end
    if (sio_clk && !prev_clk) seen.push_back(sio_dout);
    if (sio_clk) hi_cnt++;
    if (sio_ld) ld_cnt++;
    if (sio_ld && !prev_ld) ld_rises++;
    prev_clk = sio_clk;
    prev_ld  = sio_ld;
    sio_din  = (m_st == 1 && q.size() > 0) ? pat[q[0]] : 1'b0;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic clear_stats();
    hi_cnt = 0; ld_cnt = 0; ld_rises = 0; seen.delete();
  endtask

  task automatic write_cfg(input int p, input logic [11:0] d);
    @(negedge clk);
    ocfg_we = 1; ocfg_port = 5'(p); ocfg_data = d; tcfg[p] = d;
    @(negedge clk);
    ocfg_we = 0;
  endtask

  task automatic wait_load_done();
    int t = 0;
    while (!sio_ld && t < 20000) begin @(negedge clk); t++; end
    while (sio_ld && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(0, "R7 frame never completed", t, 0);
  endtask

  task automatic run_frame();
    clear_stats();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    wait_load_done();
  endtask

  function automatic logic [127:0] exp_words(input logic [31:0] m, input int w, input logic [127:0] pt);
    logic [127:0] r = '0;
    for (int p = 0; p < 32; p++)
      for (int b = 0; b <= w; b++)
        if (m[p]) r[b*32 + p] = pt[p*4 + b];
    return r;
  endfunction

  task automatic check_seq(input logic [31:0] m, input int w, input string tag);
    logic e[$];
    bit ok;
    for (int p = 0; p < 32; p++)
      if (m[p]) for (int b = 0; b <= w; b++) e.push_back(tcfg[p][b*3]);
    ok = (e.size() == seen.size());
    if (ok) foreach (e[i]) if (e[i] != seen[i]) ok = 0;
    chk(ok, tag, seen.size(), e.size());
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int nb;

  initial begin
    for (int i = 0; i < 32; i++) tcfg[i] = '0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk(in_words == '0, "R1 words after reset", in_words, 0);
    chk({sio_clk, sio_ld, sio_dout} == 3'b000, "R1 pins after reset", {sio_clk, sio_ld, sio_dout}, 0);

    // T1: cleared store, 4-bit ports, ratio 4
    cfg_width = 2'd3; cfg_div = 12'd4; cfg_port_ena = 32'h8000_0009;
    pat = 128'hA5C3_0F96_1234_5678_9ABC_DEF0_F00D_BEEF;
    run_frame();
    check_seq(cfg_port_ena, 3, "R1 zero output before writes");
    chk(in_words == exp_words(32'h8000_0009, 3, pat), "R8 regrouped inputs", in_words, exp_words(32'h8000_0009, 3, pat));
    chk(hi_cnt == 12*2, "R2 clock high cycles ratio 4", hi_cnt, 24);
    chk(ld_cnt == 4, "R7 load length ratio 4", ld_cnt, 4);

    // T2: written words, 3-bit ports, ratio 5, sparse mask
    write_cfg(0, 12'b101_110_011_001);
    write_cfg(3, 12'b000_001_000_111);
    write_cfg(5, 12'b111_110_101_010);
    write_cfg(31, 12'b110_011_110_001);
    write_cfg(1, 12'hFFF);
    cfg_width = 2'd2; cfg_div = 12'd5; cfg_port_ena = 32'h8000_0029;
    pat = 128'h5A3C_F0E1_D2C3_B4A5_9687_7869_5A4B_3C2D;
    run_frame();
    check_seq(32'h8000_0029, 2, "R4 R6 visiting order and output bits");
    chk(in_words == exp_words(32'h8000_0029, 2, pat), "R5 R8 skipped port and unused bit index", in_words, exp_words(32'h8000_0029, 2, pat));
    chk(hi_cnt == 12*3, "R2 clock high cycles ratio 5", hi_cnt, 36);
    chk(ld_cnt == 5, "R7 load length ratio 5", ld_cnt, 5);
    chk(sio_dout == 0, "R6 output low between frames", sio_dout, 0);

    // T3: divider floor
    cfg_width = 2'd0; cfg_port_ena = 32'h0000_0100;
    cfg_div = 12'd0;
    run_frame();
    chk(hi_cnt == 1 && ld_cnt == 2, "R3 divider 0 gives ratio 2", {hi_cnt[15:0], ld_cnt[15:0]}, {16'd1, 16'd2});
    cfg_div = 12'd1;
    run_frame();
    chk(hi_cnt == 1 && ld_cnt == 2, "R3 divider 1 gives ratio 2", {hi_cnt[15:0], ld_cnt[15:0]}, {16'd1, 16'd2});

    // T4: empty mask with repeat and start
    cfg_port_ena = '0; cfg_repeat = 1;
    clear_stats();
    frame_start = 1; idle(2); frame_start = 0;
    idle(60);
    chk(hi_cnt == 0 && ld_rises == 0, "R11 empty mask stays idle", {hi_cnt[15:0], ld_rises[15:0]}, 0);

    // T5: auto-repeat
    cfg_width = 2'd1; cfg_div = 12'd2; cfg_port_ena = 32'h0000_0003;
    pat = 128'h0000_0000_0000_0000_0000_0000_0000_00A5;
    clear_stats();
    idle(60);
    chk(ld_rises >= 5, "R10 frames repeat without start", ld_rises, 5);
    pat = 128'h0000_0000_0000_0000_0000_0000_0000_005A;
    idle(30);
    chk(in_words == exp_words(32'h3, 1, pat), "R9 words follow new inputs", in_words, exp_words(32'h3, 1, pat));
    cfg_repeat = 0;
    wait_load_done();
    clear_stats();
    idle(30);
    chk(ld_rises == 0, "R10 stops after repeat cleared", ld_rises, 0);

    // T6: mid-frame changes and start pulse ignored
    cfg_width = 2'd3; cfg_div = 12'd3; cfg_port_ena = 32'h0000_00F0;
    pat = 128'h0000_0000_0000_0000_1E2D_3C4B_0000_0000;
    clear_stats();
    @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0;
    idle(10);
    cfg_port_ena = 32'hFFFF_0000; cfg_width = 2'd0; cfg_div = 12'd7;
    frame_start = 1; @(negedge clk); frame_start = 0;
    wait_load_done();
    nb = 16;
    chk(hi_cnt == nb*2, "R12 frame keeps captured divider and mask", hi_cnt, nb*2);
    chk(in_words == exp_words(32'h0000_00F0, 3, pat), "R12 words from captured mask", in_words, exp_words(32'h0000_00F0, 3, pat));
    clear_stats();
    idle(40);
    chk(ld_rises == 0, "R10 start during frame ignored", ld_rises, 0);
    cfg_port_ena = '0;
    idle(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule